// File: doc/BRIEF.md
# Flag-Setting Integer Add/Subtract Unit

This block is the add/subtract execution stage of a 64-bit integer datapath. Each accepted request combines a first operand with a second operand, then registers the outcome for one cycle. The second operand takes one of two forms. In immediate form it is an unsigned 12-bit constant, which can optionally be moved up by 12 bit positions. In register form it is a register value shifted by a 6-bit count.

Four operations are supported: add, subtract, add-with-carry and subtract-with-carry. Each runs at 32-bit or 64-bit width. Subtraction is computed as the first operand plus the inverted second operand plus a carry-in. That carry-in is 1 for plain subtract and the stored carry flag for subtract-with-carry. The carry flag therefore chains multi-word sums and differences.

The four condition flags are written only when the request asks for it. A request with an encoding that has no defined meaning is reported as illegal. An illegal request changes neither the result nor the flags.

Top module: `addsub_unit`

## Requirements
- R1: A request with `in_valid` high and a legal encoding gives `out_valid` high on the following cycle, with `out_result` holding the computed value. Op code 00 is add, giving first operand plus second operand.
- R2: Op code 01 is subtract, giving first operand minus second operand (operand order is significant).
- R3: With `in_wide` low, only the low 32 bits of each operand take part and `out_result[63:32]` is zero. With `in_wide` high, all 64 bits are used.
- R4: `flags_nzcv` is laid out as N in bit 3, Z in bit 2, C in bit 1 and V in bit 0. It is written by a legal request with `in_setflags` high. Otherwise it keeps its value. All flags reset to 0.
- R5: Op code 10 (add-with-carry) adds the stored C flag as carry-in. Op code 11 (subtract-with-carry) uses the stored C flag in place of the constant 1.
- R6: With `in_use_imm` high, the second operand is `in_imm12` zero-extended (0 to 4095), shifted left by 12 when `in_imm_hi` is high. The register-form fields are ignored in this form.
- R7: With `in_use_imm` low, the second operand is `in_opb` shifted by `in_shamt`. Shift type 00 is logical left, 01 is logical right and 10 is arithmetic right. In 32-bit mode the shift works on the low word, with bit 31 as the sign.
- R8: In register form, shift type 11 is illegal. It gives `out_illegal` high and `out_valid` low on the next cycle, and leaves `out_result` and `flags_nzcv` unchanged.
- R9: In register form at 32-bit width, a shift count of 32 or more is illegal, with the same outcome as R8.
- R10: N is the sign bit of the active width and Z is set when the active-width result is zero. C is the adder carry-out, so a subtract without borrow gives C=1. V is signed overflow at the active width.
- R11: With `in_valid` low, the next cycle has `out_valid` and `out_illegal` low, and the result and flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 2 | 00 add, 01 sub, 10 add-with-carry, 11 sub-with-carry |
| in_wide | input | 1 | 1 = 64-bit, 0 = 32-bit |
| in_setflags | input | 1 | Write NZCV from this request |
| in_use_imm | input | 1 | 1 = immediate form, 0 = shifted register form |
| in_imm12 | input | 12 | Unsigned immediate |
| in_imm_hi | input | 1 | Shift immediate left by 12 |
| in_shtype | input | 2 | Register shift type |
| in_shamt | input | 6 | Register shift count |
| in_opa | input | 64 | First operand |
| in_opb | input | 64 | Second operand register value |
| out_valid | output | 1 | Registered result is new this cycle |
| out_illegal | output | 1 | Previous request was illegal |
| out_result | output | 64 | Registered result |
| flags_nzcv | output | 4 | Stored condition flags |

## Verification
The assertions assume that every control input is a known 0 or 1 whenever `in_valid` is high. They place no further limit on the inputs. Idle cycles, illegal shift types and over-long 32-bit shift counts are all legal stimulus that the properties cover. The random stimulus drives every field over its full range, including shift type 11 and counts of 32 to 63 at both widths. It mixes idle cycles with directed overflow, borrow and zero-result cases, so the illegal paths and the flag-hold path are exercised as often as the arithmetic.

// File: rtl/addsub_pkg.sv
// Shared encodings for the add/subtract unit.
// Assumes: two-bit op and shift-type fields on the request.
package addsub_pkg;
    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_ADC = 2'b10,
        OP_SBC = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_BAD = 2'b11
    } shift_e;
endpackage

// File: rtl/operand_b_gen.sv
// Builds the second adder operand from either the immediate or the shifted
// register, and reports whether the encoding is legal.
// Assumes: DATA_W is even; the half width fits in SHAMT_W bits.
module operand_b_gen
    import addsub_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int IMM_W     = 12,
    parameter int IMM_SHIFT = 12,
    parameter int SHAMT_W   = 6
) (
    input  logic              use_imm,
    input  logic              wide,
    input  logic [IMM_W-1:0]  imm,
    input  logic              imm_hi,
    input  logic [1:0]        shtype,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] opnd,
    output logic              legal
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] src_zx;
    logic [DATA_W-1:0] src_sx;
    logic [DATA_W-1:0] shifted;

    // Narrow mode sees only the low word, zero- or sign-extended.
    always_comb begin
        src_zx = wide ? opb : {{HALF_W{1'b0}}, opb[HALF_W-1:0]};
        src_sx = wide ? opb : {{HALF_W{opb[HALF_W-1]}}, opb[HALF_W-1:0]};
    end

    // Select the operand form and judge legality.
    always_comb begin
        legal   = 1'b1;
        shifted = '0;
        case (shift_e'(shtype))
            SH_LSL:  shifted = src_zx << shamt;
            SH_LSR:  shifted = src_zx >> shamt;
            SH_ASR:  shifted = DATA_W'($signed(src_sx) >>> shamt);
            default: legal   = 1'b0;
        endcase
        if (!wide && (32'(shamt) >= HALF_W)) begin
            legal = 1'b0;
        end
        if (use_imm) begin
            legal = 1'b1;
            opnd  = DATA_W'(imm) << (imm_hi ? IMM_SHIFT : 0);
        end else begin
            opnd  = wide ? shifted : {{HALF_W{1'b0}}, shifted[HALF_W-1:0]};
        end
    end
endmodule

// File: rtl/addsub_core.sv
// Width-selectable adder with optional inversion of the second operand and
// NZCV generation at the active width.
// Assumes: in narrow mode only the low halves of a and b are meaningful.
module addsub_core #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              wide,
    input  logic              sub,
    input  logic              cin,
    output logic [DATA_W-1:0] result,
    output logic [3:0]        nzcv
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   sum_full;
    logic [HALF_W:0]   sum_half;
    logic              sa, sb, sr, c_out;

    // Both widths are summed; the mode picks one.
    always_comb begin
        b_eff    = sub ? ~b : b;
        sum_full = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
        sum_half = {1'b0, a[HALF_W-1:0]} + {1'b0, b_eff[HALF_W-1:0]}
                 + {{HALF_W{1'b0}}, cin};
    end

    // Result and flags at the active width.
    always_comb begin
        if (wide) begin
            result = sum_full[DATA_W-1:0];
            c_out  = sum_full[DATA_W];
            sa     = a[DATA_W-1];
            sb     = b_eff[DATA_W-1];
        end else begin
            result = {{HALF_W{1'b0}}, sum_half[HALF_W-1:0]};
            c_out  = sum_half[HALF_W];
            sa     = a[HALF_W-1];
            sb     = b_eff[HALF_W-1];
        end
        sr   = wide ? result[DATA_W-1] : result[HALF_W-1];
        nzcv = {sr, (result == '0), c_out, (sa == sb) && (sr != sa)};
    end
endmodule

// File: rtl/addsub_unit.sv
// Top of the add/subtract unit: selects carry-in, computes, and registers the
// result, the legality indication and the condition flags.
// Assumes: control inputs are known whenever in_valid is high.
module addsub_unit
    import addsub_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int IMM_W     = 12,
    parameter int IMM_SHIFT = 12,
    parameter int SHAMT_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [1:0]         in_op,
    input  logic               in_wide,
    input  logic               in_setflags,
    input  logic               in_use_imm,
    input  logic [IMM_W-1:0]   in_imm12,
    input  logic               in_imm_hi,
    input  logic [1:0]         in_shtype,
    input  logic [SHAMT_W-1:0] in_shamt,
    input  logic [DATA_W-1:0]  in_opa,
    input  logic [DATA_W-1:0]  in_opb,
    output logic               out_valid,
    output logic               out_illegal,
    output logic [DATA_W-1:0]  out_result,
    output logic [3:0]         flags_nzcv
);
    logic [DATA_W-1:0] opnd_b;
    logic              legal;
    logic              cin;
    logic [DATA_W-1:0] sum;
    logic [3:0]        nzcv_new;
    logic              accept;

    operand_b_gen #(
        .DATA_W(DATA_W), .IMM_W(IMM_W), .IMM_SHIFT(IMM_SHIFT), .SHAMT_W(SHAMT_W)
    ) u_opb (
        .use_imm(in_use_imm), .wide(in_wide), .imm(in_imm12), .imm_hi(in_imm_hi),
        .shtype(in_shtype), .shamt(in_shamt), .opb(in_opb),
        .opnd(opnd_b), .legal(legal)
    );

    // Carry-in: constant for plain ops, stored C for the chained ops.
    always_comb begin
        case (op_e'(in_op))
            OP_ADD:  cin = 1'b0;
            OP_SUB:  cin = 1'b1;
            default: cin = flags_nzcv[1];
        endcase
    end

    addsub_core #(.DATA_W(DATA_W)) u_core (
        .a(in_opa), .b(opnd_b), .wide(in_wide), .sub(in_op[0]), .cin(cin),
        .result(sum), .nzcv(nzcv_new)
    );

    assign accept = in_valid && legal;

    // Output register stage with selective result and flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
            out_result  <= '0;
            flags_nzcv  <= '0;
        end else begin
            out_valid   <= accept;
            out_illegal <= in_valid && !legal;
            if (accept) begin
                out_result <= sum;
            end
            if (accept && in_setflags) begin
                flags_nzcv <= nzcv_new;
            end
        end
    end
endmodule

// File: rtl/addsub_unit_chk.sv
// Temporal properties of the add/subtract unit, bound onto every instance.
// Assumes: reset is held for at least one clock before use.
module addsub_unit_chk #(
    parameter int DATA_W  = 64,
    parameter int SHAMT_W = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_wide,
    input logic               in_setflags,
    input logic               in_use_imm,
    input logic [1:0]         in_shtype,
    input logic [SHAMT_W-1:0] in_shamt,
    input logic               out_valid,
    input logic               out_illegal,
    input logic [DATA_W-1:0]  out_result,
    input logic [3:0]         flags_nzcv
);
    localparam int HALF_W = DATA_W / 2;

    // R8
    bad_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_use_imm && in_shtype == 2'b11)
        |=> (out_illegal && !out_valid && $stable(out_result) && $stable(flags_nzcv)));

    // R9
    narrow_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_use_imm && !in_wide && 32'(in_shamt) >= HALF_W)
        |=> (out_illegal && !out_valid));

    // R3
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_wide) |=> (out_illegal || out_result[DATA_W-1:HALF_W] == '0));

    // R4
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_setflags) |=> $stable(flags_nzcv));

    // R10
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_setflags) |=> (out_illegal || flags_nzcv[2] == (out_result == '0)));

    // R11
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_illegal && $stable(out_result)));

    // R1
    one_pulse_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_valid, out_illegal}));
endmodule

bind addsub_unit addsub_unit_chk #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_wide(in_wide),
    .in_setflags(in_setflags), .in_use_imm(in_use_imm), .in_shtype(in_shtype),
    .in_shamt(in_shamt), .out_valid(out_valid), .out_illegal(out_illegal),
    .out_result(out_result), .flags_nzcv(flags_nzcv)
);

// File: tb/tb_addsub_unit.sv
// Bench for addsub_unit: behavioural reference model compared every cycle.
module tb_addsub_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = '0;
    logic        in_wide = 1'b0;
    logic        in_setflags = 1'b0;
    logic        in_use_imm = 1'b0;
    logic [11:0] in_imm12 = '0;
    logic        in_imm_hi = 1'b0;
    logic [1:0]  in_shtype = '0;
    logic [5:0]  in_shamt = '0;
    logic [63:0] in_opa = '0;
    logic [63:0] in_opb = '0;
    logic        out_valid, out_illegal;
    logic [63:0] out_result;
    logic [3:0]  flags_nzcv;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model state (expected registered outputs).
    logic        m_valid = 1'b0, m_ill = 1'b0;
    logic [63:0] m_res = '0;
    logic [3:0]  m_flags = '0;

    addsub_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_wide(in_wide), .in_setflags(in_setflags), .in_use_imm(in_use_imm),
        .in_imm12(in_imm12), .in_imm_hi(in_imm_hi), .in_shtype(in_shtype),
        .in_shamt(in_shamt), .in_opa(in_opa), .in_opb(in_opb),
        .out_valid(out_valid), .out_illegal(out_illegal),
        .out_result(out_result), .flags_nzcv(flags_nzcv)
    );

    always #4 clk = ~clk;

    // Compare all outputs with the model.
    task automatic compare(input string tag);
        n_checks++;
        if (out_valid !== m_valid || out_illegal !== m_ill ||
            out_result !== m_res || flags_nzcv !== m_flags) begin
            n_fail++;
            $display("FAIL %s: got v=%0b ill=%0b res=%h nzcv=%b, want v=%0b ill=%0b res=%h nzcv=%b",
                     tag, out_valid, out_illegal, out_result, flags_nzcv,
                     m_valid, m_ill, m_res, m_flags);
        end
    endtask

    // Model one request arithmetically and advance expected state.
    task automatic model_step();
        int w;
        logic [63:0] bv, av, mask;
        logic        legal, cin, sub;
        logic [66:0] ua, ub, usum;
        logic signed [66:0] sa, sb, ssum, lim;
        logic [63:0] res;
        logic        c, v;
        w = in_wide ? 64 : 32;
        mask = in_wide ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
        legal = 1'b1;
        if (in_use_imm) begin
            bv = {52'd0, in_imm12} * (in_imm_hi ? 64'd4096 : 64'd1);
        end else begin
            bv = in_opb & mask;
            if (in_shtype == 2'b11) legal = 1'b0;
            if (!in_wide && in_shamt >= 6'd32) legal = 1'b0;
            if (in_shtype == 2'b00) bv = (bv << in_shamt) & mask;
            else if (in_shtype == 2'b01) bv = bv >> in_shamt;
            else if (in_shtype == 2'b10) begin
                if (in_wide) bv = 64'($signed(in_opb) >>> in_shamt);
                else bv = 64'($signed({{32{in_opb[31]}}, in_opb[31:0]}) >>> in_shamt) & mask;
            end
        end
        av  = in_opa & mask;
        sub = in_op[0];
        cin = (in_op == 2'b00) ? 1'b0 : (in_op == 2'b01) ? 1'b1 : m_flags[1];
        ua = {3'b0, av};
        ub = {3'b0, bv};
        if (sub) begin
            usum = ua - ub - 67'd1 + {66'd0, cin};
            c    = (ua + {66'd0, cin}) > ub;
        end else begin
            usum = ua + ub + {66'd0, cin};
            c    = (usum >> w) != 0;
        end
        res = usum[63:0] & mask;
        sa = in_wide ? {{3{av[63]}}, av} : {{35{av[31]}}, av[31:0]};
        sb = in_wide ? {{3{bv[63]}}, bv} : {{35{bv[31]}}, bv[31:0]};
        ssum = sub ? (sa - sb - 67'sd1 + $signed({66'd0, cin})) : (sa + sb + $signed({66'd0, cin}));
        lim = 67'sd1 <<< (w - 1);
        v = (ssum >= lim) || (ssum < -lim);
        m_valid = in_valid && legal;
        m_ill   = in_valid && !legal;
        if (in_valid && legal) begin
            m_res = res;
            if (in_setflags) m_flags = {res[w-1], res == 64'd0, c, v};
        end
    endtask

    // Drive one request at the falling edge, check one cycle later.
    task automatic apply(input string tag, input logic vld, input logic [1:0] op,
                         input logic wide, input logic sf, input logic ui,
                         input logic [11:0] imm, input logic ihi, input logic [1:0] st,
                         input logic [5:0] sh, input logic [63:0] a, input logic [63:0] b);
        in_valid = vld; in_op = op; in_wide = wide; in_setflags = sf;
        in_use_imm = ui; in_imm12 = imm; in_imm_hi = ihi; in_shtype = st;
        in_shamt = sh; in_opa = a; in_opb = b;
        model_step();
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout, want completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R4 reset state");
        // R1 basic add
        apply("R1 add64", 1, 2'b00, 1, 1, 0, 0, 0, 2'b00, 0, 64'd1000, 64'd234);
        // R2 subtract order
        apply("R2 sub order", 1, 2'b01, 1, 1, 0, 0, 0, 2'b00, 0, 64'd5, 64'd9);
        // R10 signed overflow and zero/borrow
        apply("R10 add V", 1, 2'b00, 1, 1, 0, 0, 0, 2'b00, 0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1);
        apply("R10 sub zero", 1, 2'b01, 1, 1, 0, 0, 0, 2'b00, 0, 64'd77, 64'd77);
        // R3 narrow add wrapping
        apply("R3 narrow", 1, 2'b00, 0, 1, 0, 0, 0, 2'b00, 0, 64'hDEAD_BEEF_FFFF_FFFF, 64'h1234_0000_0000_0001);
        apply("R10 narrow V", 1, 2'b00, 0, 1, 0, 0, 0, 2'b00, 0, 64'h7FFF_FFFF, 64'd1);
        // R5 carry chain, 128-bit add
        apply("R5 lo word", 1, 2'b00, 1, 1, 0, 0, 0, 2'b00, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2);
        apply("R5 adc hi", 1, 2'b10, 1, 1, 0, 0, 0, 2'b00, 0, 64'd10, 64'd20);
        apply("R5 sbc", 1, 2'b11, 1, 1, 0, 0, 0, 2'b00, 0, 64'd10, 64'd20);
        // R6 immediate forms, register fields ignored
        apply("R6 imm max", 1, 2'b00, 1, 0, 1, 12'd4095, 0, 2'b11, 6'd63, 64'd1, 64'hFFFF);
        apply("R6 imm hi", 1, 2'b00, 1, 0, 1, 12'd3, 1, 2'b11, 6'd40, 64'd0, 64'd5);
        // R4 flags hold with setflags low
        apply("R4 hold", 1, 2'b01, 1, 0, 0, 0, 0, 2'b00, 0, 64'd0, 64'd1);
        // R7 shifts
        apply("R7 lsl", 1, 2'b00, 1, 1, 0, 0, 0, 2'b00, 6'd63, 64'd0, 64'd1);
        apply("R7 lsr", 1, 2'b00, 1, 1, 0, 0, 0, 2'b01, 6'd4, 64'd0, 64'hF000_0000_0000_0000);
        apply("R7 asr", 1, 2'b00, 1, 1, 0, 0, 0, 2'b10, 6'd4, 64'd0, 64'hF000_0000_0000_0000);
        apply("R7 asr narrow", 1, 2'b00, 0, 1, 0, 0, 0, 2'b10, 6'd31, 64'd0, 64'h0000_0000_8000_0000);
        // R8 / R9 illegal encodings
        apply("R8 bad type", 1, 2'b00, 1, 1, 0, 0, 0, 2'b11, 6'd1, 64'd9, 64'd9);
        apply("R9 narrow count", 1, 2'b00, 0, 1, 0, 0, 0, 2'b00, 6'd32, 64'd9, 64'd9);
        apply("R9 wide count ok", 1, 2'b00, 1, 1, 0, 0, 0, 2'b00, 6'd32, 64'd9, 64'd9);
        // R11 idle
        apply("R11 idle", 0, 2'b00, 1, 1, 0, 0, 0, 2'b00, 0, 64'd123, 64'd456);
        // Randomized traffic at both widths
        for (int i = 0; i < 4000; i++) begin
            logic [63:0] ra, rb;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            if ($urandom_range(0, 7) == 0) ra = ra & 64'hFF;
            apply("R1 R2 R5 R7 R10 random", ($urandom_range(0, 7) != 0),
                  2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  12'($urandom), 1'($urandom), 2'($urandom), 6'($urandom), ra, rb);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule